// File: doc/BRIEF.md
# Staggered Multi-Port Link Reset Sequencer

This block brings up six serial storage links strictly one after another, so that the status answers of fast devices can never pile up on each other. After a start pulse it sends a one-cycle link reset request to port 0. It then waits for that port's response strobe, which carries a 2-bit link speed code, or for a timeout. It keeps a fixed guard gap and only then moves on to the next port. When the last port's gap has run out, it raises a done flag and holds the speed it captured for every port.

The guard gap comes from three nested down-counters: outer, middle and inner. Each inner decrement costs a fixed number of clock cycles. With the defaults (4, 255, 255, 2 cycles) at a 25 MHz clock the gap is about 21 ms. Each load value is a parameter, so a core clock of a different speed can be compensated for by changing the outer count. A port that does not answer in time is recorded as absent. A strobe from any port other than the one being served is dropped, and it sets a sticky error flag.

Top module: `link_stagger_seq`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `done_o`, `stray_err_o`, all `link_rst_o` bits and all speed fields are 0.
- R2: A start pulse sampled while idle clears the speeds, the error flag and done, and puts out the port 0 reset pulse in the next cycle. `busy_o` stays high from that cycle until the cycle in which `done_o` rises.
- R3: Each run gives exactly one single-cycle reset pulse per port, in ascending port order from 0. At most one `link_rst_o` bit is ever high.
- R4: A response strobe from the served port during its wait window stores that port's 2-bit code in `link_spd_o[2p+1:2p]`. A code of 3 means the highest (Gen3) rate. A strobe in the last cycle of the window still counts.
- R5: If the served port gives no strobe within TMO_CYCLES wait cycles, its speed field is set to 0 (absent) and the sequence goes on. A strobe that arrives after the window is not stored.
- R6: After the wait for a port ends, a guard gap of exactly GAP_OUTER*GAP_MID*GAP_INNER*GAP_STEP cycles follows. So the next reset pulse comes 1 + k + gap cycles after the previous one, where k is the number of wait cycles used (1..TMO_CYCLES).
- R7: `done_o` rises in the cycle after the last port's gap ends, together with `busy_o` falling. It stays high, with the speeds held, until the next accepted start.
- R8: While busy, a strobe from a port other than the one being served changes no speed field and sets `stray_err_o`. That flag stays set until the next accepted start. Strobes while idle have no effect.
- R9: A start pulse while busy is ignored: no extra reset pulse, and no change to the order or timing of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a bring-up run |
| resp_vld_i | input | NPORTS | Per-port status response strobe |
| resp_spd_i | input | NPORTS*SPD_W | Per-port speed code, field p at [SPD_W*p +: SPD_W] |
| link_rst_o | output | NPORTS | Per-port single-cycle link reset request |
| link_spd_o | output | NPORTS*SPD_W | Captured speed per port, 0 = absent |
| stray_err_o | output | 1 | Sticky flag: strobe from a port not being served |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run finished |

## Verification
The bench builds the block with a 6-cycle timeout and a gap of 2 x 3 x 2 counters at 2 cycles per inner step, which is 24 cycles. With these values a whole six-port run takes under 200 cycles, so exact pulse-to-pulse spacing can be checked on every port in many runs. The short timeout makes both edges of the wait window reachable: a reply in its last cycle, and a reply one cycle too late that lands in the gap. An outer count of 2 and a middle count of 3 make every counter wrap at least once inside a gap, so a mistake in how one level hands over to the next changes the measured spacing.

// File: rtl/lss_pkg.sv
`timescale 1ns/1ps
package lss_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_GAP   = 2'd3
    } seq_st_e;
endpackage

// File: rtl/lss_wait_timer.sv
`timescale 1ns/1ps
module lss_wait_timer #(
    parameter int LIMIT = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CW'(LIMIT);
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    // high in the last cycle of the window
    assign expire_o = run_i && (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lss_guard_gap.sv
`timescale 1ns/1ps
module lss_guard_gap #(
    parameter int OUTER = 4,
    parameter int MID   = 255,
    parameter int INNER = 255,
    parameter int STEP  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int OW = $clog2(OUTER + 1);
    localparam int MW = $clog2(MID + 1);
    localparam int IW = $clog2(INNER + 1);
    localparam int SW = (STEP > 1) ? $clog2(STEP) : 1;

    typedef struct packed {
        logic [OW-1:0] outer;
        logic [MW-1:0] mid;
        logic [IW-1:0] inner;
        logic [SW-1:0] step;
    } gap_cnt_t;

    gap_cnt_t cnt_d, cnt_q;
    logic     last_step;

    assign last_step = (cnt_q.step == '0);
    assign expire_o  = run_i && last_step && (cnt_q.inner == IW'(1))
                     && (cnt_q.mid == MW'(1)) && (cnt_q.outer == OW'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.outer = OW'(OUTER);
            cnt_d.mid   = MW'(MID);
            cnt_d.inner = IW'(INNER);
            cnt_d.step  = SW'(STEP - 1);
        end else if (run_i) begin
            if (!last_step) begin
                cnt_d.step = cnt_q.step - SW'(1);
            end else begin
                cnt_d.step = SW'(STEP - 1);
                if (cnt_q.inner != IW'(1)) begin
                    cnt_d.inner = cnt_q.inner - IW'(1);
                end else begin
                    cnt_d.inner = IW'(INNER);
                    if (cnt_q.mid != MW'(1)) begin
                        cnt_d.mid = cnt_q.mid - MW'(1);
                    end else begin
                        cnt_d.mid = MW'(MID);
                        if (cnt_q.outer != OW'(1)) begin
                            cnt_d.outer = cnt_q.outer - OW'(1);
                        end else begin
                            cnt_d.outer = OW'(OUTER);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/link_stagger_seq.sv
`timescale 1ns/1ps
module link_stagger_seq
    import lss_pkg::*;
#(
    parameter int NPORTS     = 6,
    parameter int SPD_W      = 2,
    parameter int TMO_CYCLES = 12_500_000,
    parameter int GAP_OUTER  = 4,
    parameter int GAP_MID    = 255,
    parameter int GAP_INNER  = 255,
    parameter int GAP_STEP   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [NPORTS-1:0]         resp_vld_i,
    input  logic [NPORTS*SPD_W-1:0]   resp_spd_i,
    output logic [NPORTS-1:0]         link_rst_o,
    output logic [NPORTS*SPD_W-1:0]   link_spd_o,
    output logic                      stray_err_o,
    output logic                      busy_o,
    output logic                      done_o
);
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    typedef struct packed {
        seq_st_e                    st;
        logic [PW-1:0]              port;
        logic [NPORTS*SPD_W-1:0]    spd;
        logic                       err;
        logic                       done;
    } seq_t;

    seq_t               seq_d, seq_q;
    logic [NPORTS-1:0]  cur_mask;
    logic [SPD_W-1:0]   cur_code;
    logic               cur_hit, stray_hit, last_port;
    logic               wait_load, wait_run, wait_exp;
    logic               gap_load, gap_run, gap_exp;

    // one-hot of the served port and the code it presents
    always_comb begin
        cur_code = '0;
        for (int i = 0; i < NPORTS; i++) begin
            cur_mask[i] = (seq_q.port == PW'(i));
            if (cur_mask[i]) cur_code = resp_spd_i[i*SPD_W +: SPD_W];
        end
    end

    assign cur_hit   = |(resp_vld_i & cur_mask);
    assign stray_hit = |(resp_vld_i & ~cur_mask);
    assign last_port = (seq_q.port == PW'(NPORTS - 1));
    assign wait_load = (seq_q.st == ST_ISSUE);
    assign wait_run  = (seq_q.st == ST_WAIT);
    assign gap_run   = (seq_q.st == ST_GAP);
    assign gap_load  = wait_run && (cur_hit || wait_exp);

    lss_wait_timer #(.LIMIT(TMO_CYCLES)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (wait_load),
        .run_i    (wait_run),
        .expire_o (wait_exp)
    );

    lss_guard_gap #(
        .OUTER (GAP_OUTER),
        .MID   (GAP_MID),
        .INNER (GAP_INNER),
        .STEP  (GAP_STEP)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (gap_load),
        .run_i    (gap_run),
        .expire_o (gap_exp)
    );

    always_comb begin
        seq_d = seq_q;
        if (seq_q.st != ST_IDLE && stray_hit) seq_d.err = 1'b1;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st   = ST_ISSUE;
                    seq_d.port = '0;
                    seq_d.spd  = '0;
                    seq_d.err  = 1'b0;
                    seq_d.done = 1'b0;
                end
            end
            ST_ISSUE: seq_d.st = ST_WAIT;
            ST_WAIT: begin
                if (cur_hit || wait_exp) begin
                    seq_d.st = ST_GAP;
                    for (int i = 0; i < NPORTS; i++) begin
                        if (cur_mask[i])
                            seq_d.spd[i*SPD_W +: SPD_W] = cur_hit ? cur_code : '0;
                    end
                end
            end
            ST_GAP: begin
                if (gap_exp) begin
                    if (last_port) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st   = ST_ISSUE;
                        seq_d.port = seq_q.port + PW'(1);
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, port: '0, spd: '0, err: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign link_rst_o  = (seq_q.st == ST_ISSUE) ? cur_mask : '0;
    assign link_spd_o  = seq_q.spd;
    assign stray_err_o = seq_q.err;
    assign busy_o      = (seq_q.st != ST_IDLE);
    assign done_o      = seq_q.done;
endmodule

// File: rtl/lss_seq_chk.sv
`timescale 1ns/1ps
module lss_seq_chk #(
    parameter int NPORTS = 6,
    parameter int SPD_W  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic [NPORTS-1:0]       link_rst_o,
    input logic [NPORTS*SPD_W-1:0] link_spd_o,
    input logic                    stray_err_o,
    input logic                    busy_o,
    input logic                    done_o
);
    // R3
    rst_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_rst_o));

    // R3
    rst_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_rst_o != '0) |=> (link_rst_o == '0));

    // R3
    rst_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_rst_o != '0) |-> busy_o);

    // R2
    start_first_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && link_rst_o[0] && !done_o));

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R7
    spd_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(link_spd_o));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stray_err_o && !(start_i && !busy_o)) |=> stray_err_o);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !stray_err_o && link_rst_o == '0));
endmodule

bind link_stagger_seq lss_seq_chk #(.NPORTS(NPORTS), .SPD_W(SPD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .link_rst_o  (link_rst_o),
    .link_spd_o  (link_spd_o),
    .stray_err_o (stray_err_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/sim_link_stagger_seq.sv
`timescale 1ns/1ps
module sim_link_stagger_seq;
    localparam int NP  = 6;
    localparam int TMO = 6;
    localparam int GO  = 2, GM = 3, GI = 2, GS = 2;
    localparam int GAP = GO * GM * GI * GS;
    localparam int NV  = 7;
    // entry: {delay nibble per port (port p at [4p+3:4p]), 2-bit code per port}
    // delay 0 = device silent; delay > TMO = reply lands after the window
    localparam logic [35:0] VEC [NV] = '{
        {24'h111111, 12'hFFF},
        {24'h654321, 12'h6C9},
        {24'h000000, 12'hFFF},
        {24'h030501, 12'hE4D},
        {24'h666666, 12'h5A5},
        {24'h106020, 12'h3F0},
        {24'h717171, 12'hFFF}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n, start;
    logic [NP-1:0]     resp_vld, link_rst;
    logic [2*NP-1:0]   resp_spd, link_spd;
    logic              stray_err, busy, done;

    link_stagger_seq #(
        .NPORTS(NP), .SPD_W(2), .TMO_CYCLES(TMO),
        .GAP_OUTER(GO), .GAP_MID(GM), .GAP_INNER(GI), .GAP_STEP(GS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .resp_vld_i(resp_vld), .resp_spd_i(resp_spd),
        .link_rst_o(link_rst), .link_spd_o(link_spd),
        .stray_err_o(stray_err), .busy_o(busy), .done_o(done)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int dly_cfg [NP];
    int cnt [NP];
    logic [1:0] spd_cfg [NP];
    int iss [NP];
    int npulse [NP];
    int start_at = -1000, extra_at = -1000, stray_at = -1000, stray_p = 0;
    int next_exp = 0, bad_order = 0, busy_bad = 0;
    bit run_done = 1'b0, finished = 1'b0;

    task automatic check_eq(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        logic [NP-1:0]   v;
        logic [2*NP-1:0] s;
        @(negedge clk);
        cyc++;
        if (link_rst != '0) begin
            if ($countones(link_rst) != 1) bad_order++;
            for (int p = 0; p < NP; p++) begin
                if (link_rst[p]) begin
                    npulse[p]++;
                    iss[p] = cyc;
                    if (p != next_exp) bad_order++;
                    next_exp = p + 1;
                end
            end
        end
        if (cyc > start_at && !run_done && done !== 1'b1 && busy !== 1'b1) busy_bad++;
        v = '0;
        s = '0;
        for (int p = 0; p < NP; p++) begin
            if (cnt[p] == 1) begin
                v[p] = 1'b1;
                s[2*p +: 2] = spd_cfg[p];
            end
            if (cnt[p] > 0) cnt[p]--;
            if (link_rst[p] && dly_cfg[p] != 0) cnt[p] = dly_cfg[p];
        end
        if (cyc == stray_at) begin
            v[stray_p] = 1'b1;
            s[2*stray_p +: 2] = 2'd3;
        end
        resp_vld = v;
        resp_spd = s;
        start    = (cyc == start_at) || (cyc == extra_at);
    endtask

    task automatic run_vec(input logic [23:0] d, input logic [11:0] s,
                           input int stray_rel, input int sp,
                           input int extra_rel, input int exp_err, input string tag);
        int t, k, dd, guard, ev;
        for (int p = 0; p < NP; p++) begin
            dly_cfg[p] = int'(d[4*p +: 4]);
            spd_cfg[p] = s[2*p +: 2];
            cnt[p] = 0; iss[p] = -1; npulse[p] = 0;
        end
        next_exp = 0; bad_order = 0; busy_bad = 0; run_done = 1'b0;
        start_at = cyc + 1;
        extra_at = (extra_rel > 0) ? start_at + extra_rel : -1000;
        stray_at = (stray_rel > 0) ? start_at + stray_rel : -1000;
        stray_p  = sp;
        guard = 0;
        while (!run_done && guard < 3000) begin
            step();
            guard++;
            if (done === 1'b1 && cyc > start_at) run_done = 1'b1;
        end
        check_eq("R7", {tag, " run finished"}, int'(run_done), 1);
        t = start_at + 1;
        for (int p = 0; p < NP; p++) begin
            dd = dly_cfg[p];
            k  = (dd >= 1 && dd <= TMO) ? dd : TMO;
            // R2 first pulse timing, R6 spacing
            check_eq(p == 0 ? "R2" : "R6", $sformatf("%s reset cycle port %0d", tag, p), iss[p], t);
            t = t + 1 + k + GAP;
            ev = (dd >= 1 && dd <= TMO) ? int'(spd_cfg[p]) : 0;
            // R4 captured code, R5 absent or late
            check_eq(ev != 0 ? "R4" : "R5", $sformatf("%s speed port %0d", tag, p),
                     int'(link_spd[2*p +: 2]), ev);
            check_eq("R3", $sformatf("%s pulses port %0d", tag, p), npulse[p], 1);
        end
        check_eq("R7", {tag, " done cycle"}, cyc, t);
        check_eq("R3", {tag, " order errors"}, bad_order, 0);
        check_eq("R2", {tag, " busy gaps"}, busy_bad, 0);
        check_eq("R8", {tag, " stray flag"}, int'(stray_err), exp_err);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int snap;
        rst_n = 1'b0; start = 1'b0; resp_vld = '0; resp_spd = '0;
        for (int p = 0; p < NP; p++) begin
            dly_cfg[p] = 0; cnt[p] = 0; spd_cfg[p] = 2'd0; npulse[p] = 0; iss[p] = -1;
        end
        repeat (4) step();
        // R1 values while reset is held
        check_eq("R1", "busy in reset", int'(busy), 0);
        check_eq("R1", "reset pulses in reset", int'(link_rst), 0);
        rst_n = 1'b1;
        step();
        check_eq("R1", "done after reset", int'(done), 0);
        check_eq("R1", "stray flag after reset", int'(stray_err), 0);
        check_eq("R1", "speeds after reset", int'(link_spd), 0);

        // R8 strobes while idle are ignored
        stray_at = cyc + 2; stray_p = 3;
        repeat (4) step();
        check_eq("R8", "idle strobe flag", int'(stray_err), 0);
        check_eq("R8", "idle strobe speeds", int'(link_spd), 0);
        check_eq("R8", "idle strobe busy", int'(busy), 0);

        for (int v = 0; v < NV; v++)
            run_vec(VEC[v][35:12], VEC[v][11:0], 0, 0, 0, 0, $sformatf("vec%0d", v));

        // R7 done and speeds held while idle
        snap = int'(link_spd);
        repeat (10) step();
        check_eq("R7", "done held", int'(done), 1);
        check_eq("R7", "busy low when done", int'(busy), 0);
        check_eq("R7", "speeds held", int'(link_spd), snap);

        // R8 stray strobe on port 4 during port 1's wait window; port 4 itself silent
        run_vec(24'h202222, 12'hFFF, 1 + (1 + 2 + GAP) + 1, 4, 0, 1, "stray");
        repeat (5) step();
        check_eq("R8", "stray flag sticky", int'(stray_err), 1);

        // R9 start while busy ignored; also R8 flag cleared by accepted start
        run_vec(24'h333333, 12'h9C6, 0, 0, 10, 0, "restart");
        run_vec(24'h111111, 12'h1B2, 0, 0, 1 + 1 + 1 + GAP + 3, 0, "restart_late");
        check_eq("R9", "restart_late port 0 pulses", npulse[0], 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule